// File: doc/BRIEF.md
# I2C Register-Pointer Slave Controller

This block is an I2C/SMBus slave that runs from a fast system clock and oversamples the bus. It gives a master access to a bank of four 8-bit registers that sit outside the block. Both bus lines first pass through a synchronizer and a majority vote. The block then detects START, repeated START and STOP, and it compares the received address with a fixed five-bit prefix plus two strap inputs. If the address matches, the slave acknowledges. It takes the next byte of a write as a register pointer, then turns later bytes into write strobes on a simple register bus. The slave pulls SDA low through an open-drain enable. It never drives the line high.

The pointer is never advanced by the slave. Every data byte of a write goes to the register most recently selected, and so does every byte of any later read. A read is normally done by writing a command byte, then issuing a repeated START with the read bit set. The slave loads one byte from the register bus on each SCL falling edge that ends an acknowledge. Each load comes with a one-cycle read strobe, which the register bank uses to clear its interrupt when the input register is read.

Top module: `i2c_ptr_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal 1110, 0, strap bit 1, strap bit 0 (sent MSB first), with the R/W bit last (0 = write, 1 = read). An acknowledge means SDA is held low during the ninth clock.
- R2: The first byte after a write address is acknowledged and sets `reg_ptr` to its two low bits. A value above 3 therefore selects register (value mod 4).
- R3: Each later byte of a write is acknowledged and gives one `reg_wr` pulse with `reg_wdata` equal to the byte. `reg_ptr` stays unchanged across any number of bytes.
- R4: A data byte written while the pointer is 0 is acknowledged but produces no `reg_wr` pulse.
- R5: After a read address, the slave sends `reg_rdata` MSB first. It loads a fresh copy for every byte, always from the same pointer, and the pointer carries over from earlier transactions.
- R6: `reg_rd` pulses exactly once for every byte loaded for transmission. No pulse follows a byte that the master did not acknowledge.
- R7: After a NACK from the master, the slave releases SDA and ignores all clocks until the next START.
- R8: On an address mismatch, the slave drives nothing and produces no strobes until a new START. A matching address after that START is acknowledged again.
- R9: A STOP at any bit position releases SDA and aborts the byte in progress without a strobe. The pointer keeps its value.
- R10: While `rst_n` is low, `sda_oe`, `reg_wr` and `reg_rd` are 0 and `reg_ptr` is 0, whatever happens on the bus.
- R11: A pulse one system clock wide on SCL or SDA is rejected. It neither adds a bit nor creates a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset; holds all state at defaults |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| addr_strap | input | 2 | Low two address bits from board straps |
| sda_oe | output | 1 | 1 = pull SDA low |
| reg_ptr | output | 2 | Register pointer from the command byte |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe, one per byte loaded |
| reg_wdata | output | 8 | Data for the write strobe |
| reg_rdata | input | 8 | Data of the register at `reg_ptr` |

## Verification
The writes use several pointer values, including a command above 3 and the input register. Together these separate correct pointer decoding and the write suppression for pointer 0 from a slave that increments its pointer or strobes every byte. The reads use both the pointer left over from earlier transactions and a pointer set just before a repeated START. The input value changes between bytes, which shows whether each byte is loaded fresh. Mismatched addresses, clocks sent after a NACK, and a STOP in the middle of a byte all show whether the slave stays silent. Single-cycle glitches on both lines, set on every bit of a transaction, show whether the filter stops false edges and false START or STOP events.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = 2;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } slv_state_e;

    typedef struct packed {
        slv_state_e         state;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  shr;
        logic [BYTE_W-1:0]  tx;
        logic               rw;
        logic               nack;
        logic               oe;
        logic [PTR_W-1:0]   ptr;
        logic [BYTE_W-1:0]  wdata;
        logic               wr;
        logic               rd;
    } slv_regs_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int HALF = VOTE_TAPS / 2;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [VOTE_TAPS-1:0]   hist;
        logic                   out;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d      = flt_q;
        flt_d.sync = {flt_q.sync[SYNC_STAGES-2:0], line_i};
        flt_d.hist = {flt_q.hist[VOTE_TAPS-2:0], flt_q.sync[SYNC_STAGES-1]};
        flt_d.out  = ($countones(flt_q.hist) > HALF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '1;
        else        flt_q <= flt_d;
    end

    assign line_o = flt_q.out;

    // R11: a filtered level lasts at least two cycles
    p_min_width_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_o) |=> line_o);
    p_min_width_lo_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_o) |=> !line_o);
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic ev_rise,
    output logic ev_fall,
    output logic ev_start,
    output logic ev_stop
);
    typedef struct packed {
        logic scl_p;
        logic sda_p;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } ev_t;

    ev_t ev_d, ev_q;

    always_comb begin
        ev_d       = ev_q;
        ev_d.scl_p = scl_f;
        ev_d.sda_p = sda_f;
        ev_d.rise  = scl_f & ~ev_q.scl_p;
        ev_d.fall  = ~scl_f & ev_q.scl_p;
        ev_d.start = scl_f & ev_q.scl_p & ev_q.sda_p & ~sda_f;
        ev_d.stop  = scl_f & ev_q.scl_p & ~ev_q.sda_p & sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= '{scl_p: 1'b1, sda_p: 1'b1, default: 1'b0};
        else        ev_q <= ev_d;
    end

    assign ev_rise  = ev_q.rise;
    assign ev_fall  = ev_q.fall;
    assign ev_start = ev_q.start;
    assign ev_stop  = ev_q.stop;
endmodule

// File: rtl/i2c_ptr_fsm.sv
module i2c_ptr_fsm
    import i2c_ptr_pkg::*;
#(
    parameter int                         ADDR_W     = 7,
    parameter int                         STRAP_W    = 2,
    parameter logic [ADDR_W-STRAP_W-1:0]  ADDR_FIXED = 5'b11100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_rise,
    input  logic                ev_fall,
    input  logic                ev_start,
    input  logic                ev_stop,
    input  logic                sda_f,
    input  logic [STRAP_W-1:0]  addr_strap,
    input  logic [BYTE_W-1:0]   reg_rdata,
    output logic                sda_oe,
    output logic [PTR_W-1:0]    reg_ptr,
    output logic                reg_wr,
    output logic                reg_rd,
    output logic [BYTE_W-1:0]   reg_wdata
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    slv_regs_t s_d, s_q;
    logic      addr_hit;

    assign addr_hit = (s_q.shr[BYTE_W-1:1] == {ADDR_FIXED, addr_strap});

    always_comb begin
        s_d    = s_q;
        s_d.wr = 1'b0;
        s_d.rd = 1'b0;
        if (ev_start) begin
            s_d.state = ST_ADDR;
            s_d.cnt   = '0;
            s_d.oe    = 1'b0;
        end else if (ev_stop) begin
            s_d.state = ST_IDLE;
            s_d.oe    = 1'b0;
        end else begin
            unique case (s_q.state)
                ST_ADDR, ST_CMD, ST_WDATA: begin
                    if (ev_rise) begin
                        s_d.shr = {s_q.shr[BYTE_W-2:0], sda_f};
                        s_d.cnt = s_q.cnt + 1'b1;
                    end else if (ev_fall && s_q.cnt == FULL) begin
                        if (s_q.state == ST_ADDR) begin
                            if (addr_hit) begin
                                s_d.oe    = 1'b1;
                                s_d.rw    = s_q.shr[0];
                                s_d.state = ST_ADDR_ACK;
                            end else begin
                                s_d.state = ST_IDLE;
                            end
                        end else if (s_q.state == ST_CMD) begin
                            s_d.ptr   = s_q.shr[PTR_W-1:0];
                            s_d.oe    = 1'b1;
                            s_d.state = ST_CMD_ACK;
                        end else begin
                            s_d.wdata = s_q.shr;
                            s_d.wr    = (s_q.ptr != '0);
                            s_d.oe    = 1'b1;
                            s_d.state = ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (ev_fall) begin
                        s_d.cnt = '0;
                        if (s_q.rw) begin
                            s_d.tx    = reg_rdata;
                            s_d.rd    = 1'b1;
                            s_d.oe    = ~reg_rdata[BYTE_W-1];
                            s_d.state = ST_RDATA;
                        end else begin
                            s_d.oe    = 1'b0;
                            s_d.state = ST_CMD;
                        end
                    end
                end
                ST_CMD_ACK, ST_WDATA_ACK: begin
                    if (ev_fall) begin
                        s_d.oe    = 1'b0;
                        s_d.cnt   = '0;
                        s_d.state = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (ev_fall) begin
                        if (s_q.cnt == LAST) begin
                            s_d.oe    = 1'b0;
                            s_d.state = ST_RACK;
                        end else begin
                            s_d.tx  = {s_q.tx[BYTE_W-2:0], 1'b0};
                            s_d.cnt = s_q.cnt + 1'b1;
                            s_d.oe  = ~s_q.tx[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (ev_rise) begin
                        s_d.nack = sda_f;
                    end else if (ev_fall) begin
                        if (s_q.nack) begin
                            s_d.state = ST_IDLE;
                            s_d.oe    = 1'b0;
                        end else begin
                            s_d.tx    = reg_rdata;
                            s_d.rd    = 1'b1;
                            s_d.oe    = ~reg_rdata[BYTE_W-1];
                            s_d.cnt   = '0;
                            s_d.state = ST_RDATA;
                        end
                    end
                end
                default: s_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign sda_oe    = s_q.oe;
    assign reg_ptr   = s_q.ptr;
    assign reg_wr    = s_q.wr;
    assign reg_rd    = s_q.rd;
    assign reg_wdata = s_q.wdata;

    p_start_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> !sda_oe);
    p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> !sda_oe);
    p_no_wr_ptr0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> (reg_ptr != '0));
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));
    p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd) |-> $stable(reg_ptr));
    p_oe_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> ($past(ev_fall) || $past(ev_start) || $past(ev_stop)));
endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave
    import i2c_ptr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic [1:0]          addr_strap,
    output logic                sda_oe,
    output logic [PTR_W-1:0]    reg_ptr,
    output logic                reg_wr,
    output logic                reg_rd,
    output logic [BYTE_W-1:0]   reg_wdata,
    input  logic [BYTE_W-1:0]   reg_rdata
);
    localparam int N_LINES  = 2;
    localparam int LINE_SDA = 0;
    localparam int LINE_SCL = 1;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] flt_lines;
    logic ev_rise, ev_fall, ev_start, ev_stop;

    assign raw_lines = {scl_i, sda_i};

    for (genvar li = 0; li < N_LINES; li++) begin : g_flt
        i2c_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .VOTE_TAPS  (VOTE_TAPS)
        ) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw_lines[li]),
            .line_o(flt_lines[li])
        );
    end

    i2c_bus_events u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (flt_lines[LINE_SCL]),
        .sda_f   (flt_lines[LINE_SDA]),
        .ev_rise (ev_rise),
        .ev_fall (ev_fall),
        .ev_start(ev_start),
        .ev_stop (ev_stop)
    );

    i2c_ptr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_rise   (ev_rise),
        .ev_fall   (ev_fall),
        .ev_start  (ev_start),
        .ev_stop   (ev_stop),
        .sda_f     (flt_lines[LINE_SDA]),
        .addr_strap(addr_strap),
        .reg_rdata (reg_rdata),
        .sda_oe    (sda_oe),
        .reg_ptr   (reg_ptr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata)
    );
endmodule

// File: tb/i2c_ptr_slave_test.sv
module i2c_ptr_slave_test;
    localparam int Q = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic       sda_oe, reg_wr, reg_rd;
    logic [1:0] reg_ptr;
    logic [7:0] reg_wdata, reg_rdata;
    wire        sda_line = sda_m & ~sda_oe;

    logic [7:0] bank [4];
    logic [7:0] pins = 8'h00;
    int vectors = 0, fails = 0, wr_cnt = 0, rd_cnt = 0;
    logic [7:0] last_wd = 8'h00;
    logic quiet = 1'b0;

    always #4 clk = ~clk;

    i2c_ptr_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .addr_strap(strap), .sda_oe(sda_oe), .reg_ptr(reg_ptr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    assign reg_rdata = (reg_ptr == 2'd0) ? pins : bank[reg_ptr];

    initial for (int i = 0; i < 4; i++) bank[i] = 8'h00;

    always @(posedge clk) begin
        if (reg_wr) begin
            bank[reg_ptr] <= reg_wdata;
            last_wd <= reg_wdata;
            wr_cnt++;
        end
        if (reg_rd) rd_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // per-clock reference comparison: reset state and silent windows
    always @(negedge clk) begin
        if (!rst_n)
            chk("R10 held", {sda_oe, reg_wr, reg_rd, reg_ptr}, 0);
        if (quiet)
            chk("R7/R8 silent", sda_oe, 0);
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic m, input logic g, output logic s);
        tick(Q/2); sda_m = m; tick(Q/2); scl = 1'b1; tick(Q/2);
        if (g) begin
            scl = 1'b0; tick(1); scl = 1'b1; tick(2);
            if (m) begin sda_m = 1'b0; tick(1); sda_m = 1'b1; end
        end
        tick(Q/2); s = sda_line; scl = 1'b0;
    endtask

    task automatic bus_start();
        tick(Q/2); sda_m = 1'b1; tick(Q/2); scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q/2); sda_m = 1'b0; tick(Q/2); scl = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, input logic g, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(d[i], g, s);
        clk_bit(1'b1, 1'b0, s);
        ack = !s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, 1'b0, s); d[i] = s; end
        clk_bit(!mack, 1'b0, s);
    endtask

    localparam logic [7:0] AW = 8'b1110_0100;
    localparam logic [7:0] AR = 8'b1110_0101;

    initial begin
        logic a, s;
        logic [7:0] d;
        tick(10);
        chk("R10 reset ptr", reg_ptr, 0);
        chk("R10 reset oe", sda_oe, 0);
        // bus traffic during reset
        quiet = 1'b1;
        bus_start(); send_byte(AW, 0, a); chk("R10 no ack in reset", a, 0);
        send_byte(8'h02, 0, a); bus_stop();
        chk("R10 no strobe", wr_cnt, 0);
        quiet = 1'b0;
        rst_n = 1'b1; tick(10);

        // basic write, two bytes to pointer 2
        bus_start(); send_byte(AW, 0, a); chk("R1 addr ack", a, 1);
        send_byte(8'h02, 0, a); chk("R2 cmd ack", a, 1);
        chk("R2 ptr", reg_ptr, 2);
        send_byte(8'hA5, 0, a); chk("R3 data ack", a, 1);
        chk("R3 wdata", last_wd, 8'hA5);
        send_byte(8'h3C, 0, a); chk("R3 data ack 2", a, 1);
        bus_stop();
        chk("R3 wr count", wr_cnt, 2);
        chk("R3 bank2", bank[2], 8'h3C);
        chk("R3 ptr kept", reg_ptr, 2);

        // command above 3 wraps to 3
        bus_start(); send_byte(AW, 0, a);
        send_byte(8'h07, 0, a); chk("R2 big cmd ack", a, 1);
        chk("R2 ptr wrap", reg_ptr, 3);
        send_byte(8'h5A, 0, a); bus_stop();
        chk("R2 bank3", bank[3], 8'h5A);

        // write to pointer 0 is acked, no strobe
        bus_start(); send_byte(AW, 0, a); send_byte(8'h00, 0, a);
        send_byte(8'hFF, 0, a); chk("R4 ack", a, 1);
        bus_stop();
        chk("R4 no wr", wr_cnt, 3);
        chk("R4 ptr0", reg_ptr, 0);

        // read with carried-over pointer 0, fresh load per byte
        pins = 8'h96;
        bus_start(); send_byte(AR, 0, a); chk("R5 read addr ack", a, 1);
        recv_byte(1, d); chk("R5 byte0", d, 8'h96);
        pins = 8'h4B;
        recv_byte(0, d); chk("R5 byte1 fresh", d, 8'h4B);
        bus_stop();
        chk("R6 rd count 2", rd_cnt, 2);

        // command then repeated start, three-byte read
        bus_start(); send_byte(AW, 0, a); send_byte(8'h02, 0, a);
        bus_start(); send_byte(AR, 0, a); chk("R5 rs addr ack", a, 1);
        recv_byte(1, d); chk("R5 rs b0", d, 8'h3C);
        recv_byte(1, d); chk("R5 rs b1", d, 8'h3C);
        recv_byte(0, d); chk("R5 rs b2", d, 8'h3C);
        chk("R6 rd count 5", rd_cnt, 5);
        // clocks after NACK are ignored
        quiet = 1'b1;
        send_byte(8'hE4, 0, a); chk("R7 no ack after nack", a, 0);
        quiet = 1'b0;
        bus_stop();
        chk("R7 rd unchanged", rd_cnt, 5);
        chk("R7 wr unchanged", wr_cnt, 3);
        chk("R5 ptr after read", reg_ptr, 2);

        // address mismatch
        bus_start(); quiet = 1'b1;
        send_byte(8'b1110_0000, 0, a); chk("R8 mismatch no ack", a, 0);
        send_byte(8'h11, 0, a); chk("R8 data no ack", a, 0);
        quiet = 1'b0;
        chk("R8 no wr", wr_cnt, 3);
        bus_start(); send_byte(AW, 0, a); chk("R8 reacquire ack", a, 1);
        send_byte(8'h03, 0, a); bus_stop();
        chk("R8 ptr", reg_ptr, 3);

        // STOP in mid-byte
        bus_start(); send_byte(AW, 0, a); send_byte(8'h01, 0, a);
        for (int i = 0; i < 4; i++) clk_bit(i[0], 0, s);
        bus_stop();
        chk("R9 oe released", sda_oe, 0);
        chk("R9 no wr", wr_cnt, 3);
        chk("R9 ptr kept", reg_ptr, 1);
        bus_start(); send_byte(AW, 0, a); send_byte(8'h01, 0, a);
        send_byte(8'h77, 0, a); chk("R9 after stop ack", a, 1);
        bus_stop();
        chk("R9 bank1", bank[1], 8'h77);

        // single-cycle glitches on both lines
        bus_start(); send_byte(AW, 1, a); chk("R11 addr ack", a, 1);
        send_byte(8'h02, 1, a); chk("R11 cmd ack", a, 1);
        send_byte(8'hC3, 1, a); chk("R11 data ack", a, 1);
        bus_stop();
        chk("R11 bank2", bank[2], 8'hC3);
        chk("R11 wr count", wr_cnt, 5);

        // strap change
        strap = 2'b01; tick(4);
        bus_start(); send_byte(8'b1110_0010, 0, a); chk("R1 strap 01 ack", a, 1);
        bus_stop();
        bus_start(); send_byte(AW, 0, a); chk("R1 old addr nack", a, 0);
        bus_stop();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule